// File: doc/BRIEF.md
# Masked Memory Checksum Accumulator

This block folds a stream of address-tagged bytes, typically a read-back of a program memory, into a 16-bit checksum. Plain code bytes that sit below the configuration region are added as they are. Each of the eight bytes in the configuration region is ANDed with a fixed mask that depends on its offset from the region base before it is added. Some of these bytes are dropped entirely. Bytes above the region are ignored.

A start pulse clears the accumulator. It also captures two static selects: the memory size, which places the configuration region, and the package variant, which picks the masks for offsets 4 and 5. The byte flagged as last closes the run. One cycle later the done flag rises and the checksum appears on the output. If code protection is active when the last byte is taken, the reported checksum is zero. The result stays on the output until the next start pulse. The block does not generate the addresses; the stream's producer supplies them.

Top module: `cfg_checksum_acc`

## Requirements
- R1: After reset, `done_o` is 0 and `sum_o` is 0x0000, and no byte is accepted until a start pulse.
- R2: A start pulse clears the accumulator and `done_o`. A byte strobed in the same cycle as the start pulse is not added.
- R3: A byte whose address is below the configuration base is added unmasked. The sum is kept modulo 2^16.
- R4: Configuration bytes at offsets 0, 1, 2 and 3 from the base are ANDed with 0xE1, 0x0C, 0xC7 and 0x0F respectively before they are added.
- R5: The variant select is encoded as 0 = largest package, 1 = middle, 2 or 3 = smallest. On variant 0, offset 4 uses mask 0xF8 and offset 5 uses 0x07. On variant 1, offset 4 is excluded and offset 5 uses 0x07. On variants 2 and 3, offset 4 is excluded and offset 5 uses 0x04.
- R6: Bytes at offsets 6 and 7, and bytes at any address at or beyond base + 8, add nothing.
- R7: The size select places the configuration base: 0 gives 0x00FFF8, 1 gives 0x017FF8, and 2 or 3 give 0x01FFF8. Both selects are sampled at the start pulse, and later changes do not affect the run in progress.
- R8: If `code_prot_i` is 1 in the cycle the last byte is accepted, the reported checksum is 0x0000.
- R9: `done_o` rises on the clock edge after the one that accepts the last byte. It then stays high and `sum_o` stays unchanged until the next start pulse. Bytes strobed in that interval are ignored.
- R10: While `done_o` is 0, `sum_o` reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the accumulator and samples the selects |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Data byte |
| addr_i | input | ADDR_W (24) | Byte address |
| last_i | input | 1 | Marks the final byte of the run (qualified by the strobe) |
| code_prot_i | input | 1 | Code protection active; forces a zero result |
| size_sel_i | input | 2 | Memory size select |
| pins_sel_i | input | 2 | Package variant select |
| sum_o | output | 16 | Checksum result |
| done_o | output | 1 | Result valid |

## Verification
The bench builds the block with its default 24-bit address width. This width reaches all three configuration bases, addresses past the top of each region, and the gap between the smaller bases and the largest one. It runs every combination of size and variant that changes a mask or a base. It also feeds a run long enough to wrap the 16-bit sum. Further scenarios cover a change of selects in the middle of a run and traffic in the idle window after done.

// File: rtl/cfg_checksum_acc.sv
module cfg_checksum_acc #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              last_i,
  input  logic              code_prot_i,
  input  logic [1:0]        size_sel_i,
  input  logic [1:0]        pins_sel_i,
  output logic [15:0]       sum_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] BASE_S = ADDR_W'(32'h0000_FFF8);
  localparam logic [ADDR_W-1:0] BASE_M = ADDR_W'(32'h0001_7FF8);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(32'h0001_FFF8);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(8);

  logic              busy;
  logic [1:0]        size_q, pins_q;
  logic [15:0]       acc, res;
  logic [ADDR_W-1:0] base, off;
  logic              is_code, is_cfg, take;
  logic [7:0]        mask, addend;
  logic [15:0]       nxt;

  always_comb begin
    case (size_q)
      2'd0:    base = BASE_S;
      2'd1:    base = BASE_M;
      default: base = BASE_L;
    endcase
  end

  assign off     = addr_i - base;
  assign is_code = addr_i < base;
  assign is_cfg  = !is_code && (off < CFG_SPAN);

  always_comb begin
    case (off[2:0])
      3'd0:    mask = 8'hE1;
      3'd1:    mask = 8'h0C;
      3'd2:    mask = 8'hC7;
      3'd3:    mask = 8'h0F;
      3'd4:    mask = (pins_q == 2'd0) ? 8'hF8 : 8'h00;
      3'd5:    mask = (pins_q[1] == 1'b0) ? 8'h07 : 8'h04;
      default: mask = 8'h00;
    endcase
  end

  assign addend = is_code ? byte_i : (is_cfg ? (byte_i & mask) : 8'h00);
  assign take   = byte_vld_i && busy && !start_i;
  assign nxt    = acc + {8'h00, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_o <= 1'b0;
      acc    <= '0;
      res    <= '0;
      size_q <= '0;
      pins_q <= '0;
    end else if (start_i) begin
      busy   <= 1'b1;
      done_o <= 1'b0;
      acc    <= '0;
      res    <= '0;
      size_q <= size_sel_i;
      pins_q <= pins_sel_i;
    end else if (take) begin
      acc <= nxt;
      if (last_i) begin
        busy   <= 1'b0;
        done_o <= 1'b1;
        res    <= code_prot_i ? 16'h0000 : nxt;
      end
    end
  end

  assign sum_o = res;

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i) |=> done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(sum_o)));

  // R8
  prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_i && code_prot_i) |=> (sum_o == 16'h0000));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && sum_o == 16'h0000));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (sum_o == 16'h0000));
endmodule

// File: tb/test_cfg_checksum_acc.sv
module test_cfg_checksum_acc;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, byte_vld_i = 0, last_i = 0, code_prot_i = 0;
  logic [7:0] byte_i = 0;
  logic [AW-1:0] addr_i = 0;
  logic [1:0] size_sel_i = 0, pins_sel_i = 0;
  logic [15:0] sum_o;
  logic done_o;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cfg_checksum_acc #(.ADDR_W(AW)) i_cfg_checksum_acc (
    .clk, .rst_n, .start_i, .byte_vld_i, .byte_i, .addr_i, .last_i,
    .code_prot_i, .size_sel_i, .pins_sel_i, .sum_o, .done_o);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] base_of(input logic [1:0] s);
    return (s == 0) ? 24'h00FFF8 : (s == 1) ? 24'h017FF8 : 24'h01FFF8;
  endfunction

  task automatic begin_run(input logic [1:0] s, input logic [1:0] p);
    @(negedge clk);
    size_sel_i = s; pins_sel_i = p; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic put(input logic [23:0] a, input logic [7:0] d, input logic lst);
    addr_i = a; byte_i = d; last_i = lst; byte_vld_i = 1;
    @(negedge clk);
    byte_vld_i = 0; last_i = 0;
  endtask

  task automatic t_reset;
    check("R1 done", {15'd0, done_o}, 16'd0);
    check("R1 sum", sum_o, 16'h0000);
    @(negedge clk); put(24'h10, 8'h55, 1);
    check("R1 no accept before start", {15'd0, done_o}, 16'd0);
  endtask

  task automatic t_code;
    logic [15:0] e = 0;
    begin_run(0, 0);
    for (int i = 0; i < 10; i++) begin
      put(24'(i), 8'(i * 17 + 3), i == 9);
      e += 16'(i * 17 + 3);
    end
    check("R9 done", {15'd0, done_o}, 16'd1);
    check("R3 code sum", sum_o, e);
  endtask

  task automatic t_cfg(input logic [1:0] s, input logic [1:0] p, input logic [15:0] e, input string req);
    logic [23:0] b = base_of(s);
    begin_run(s, p);
    for (int i = 0; i < 8; i++) put(b + 24'(i), 8'hFF, 0);
    put(b + 24'd8, 8'hFF, 0);
    put(24'h1FFFFF, 8'hFF, 1);
    check(req, sum_o, e);
  endtask

  task automatic t_prot;
    begin_run(1, 0);
    put(24'h0, 8'h80, 0);
    code_prot_i = 1;
    put(24'h1, 8'h80, 1);
    code_prot_i = 0;
    check("R8 done", {15'd0, done_o}, 16'd1);
    check("R8 zero", sum_o, 16'h0000);
  endtask

  task automatic t_wrap;
    begin_run(2, 0);
    for (int i = 0; i < 258; i++) put(24'(i), 8'hFF, i == 257);
    check("R3 wrap", sum_o, 16'd254);
  endtask

  task automatic t_hold_start;
    begin_run(0, 0);
    put(24'h20, 8'h12, 1);
    put(24'h21, 8'h40, 1);
    repeat (3) @(negedge clk);
    check("R9 hold sum", sum_o, 16'h0012);
    check("R9 hold done", {15'd0, done_o}, 16'd1);
    @(negedge clk);
    size_sel_i = 0; start_i = 1; byte_vld_i = 1; addr_i = 24'h5; byte_i = 8'h77;
    @(negedge clk);
    start_i = 0; byte_vld_i = 0;
    check("R2 cleared", {15'd0, done_o}, 16'd0);
    check("R10 idle sum", sum_o, 16'h0000);
    put(24'h6, 8'h01, 1);
    check("R2 same-cycle byte ignored", sum_o, 16'h0001);
  endtask

  task automatic t_latch;
    begin_run(0, 0);
    size_sel_i = 2; pins_sel_i = 2;
    put(24'h00FFF8, 8'hFF, 0);
    put(24'h00FFFC, 8'hFF, 0);
    put(24'h00FFFD, 8'hFF, 0);
    put(24'h01FFF8, 8'hFF, 1);
    check("R7 selects latched", sum_o, 16'h00E1 + 16'h00F8 + 16'h0007);
  endtask

  task automatic t_base_edge;
    begin_run(1, 2);
    put(24'h017FF7, 8'hFF, 0);
    put(24'h017FF8, 8'hFF, 0);
    put(24'h017FFD, 8'hFF, 1);
    check("R7 mid base", sum_o, 16'h00FF + 16'h00E1 + 16'h0004);
    begin_run(0, 0);
    put(24'h00FFF7, 8'hFF, 0);
    put(24'h017FF7, 8'hFF, 1);
    check("R6 above region", sum_o, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_code;
    t_cfg(0, 0, 16'h00E1 + 16'h000C + 16'h00C7 + 16'h000F + 16'h00F8 + 16'h0007, "R4 R5 R6 variant 0");
    t_cfg(1, 1, 16'h00E1 + 16'h000C + 16'h00C7 + 16'h000F + 16'h0007, "R5 variant 1");
    t_cfg(2, 2, 16'h00E1 + 16'h000C + 16'h00C7 + 16'h000F + 16'h0004, "R5 variant 2");
    t_cfg(3, 3, 16'h00E1 + 16'h000C + 16'h00C7 + 16'h000F + 16'h0004, "R7 R5 select 3");
    t_prot;
    t_wrap;
    t_hold_start;
    t_latch;
    t_base_edge;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule